// File: doc/BRIEF.md
# Relay Channel Switchover Sequencer

The block drives three relay enables from three switch lines that pull low to request a channel. Each switch line is brought into the clock domain, debounced, and passed to a priority picker that names one requested channel. A sequencer then moves the active enable from the old channel to the new one. The caller's mode bit picks how the two edges are ordered. In overlap mode the new relay closes before the old one opens, so the two are on together for a while. In deadband mode the old relay opens first, and all relays stay off for a gap before the new one closes.

All timing runs on an internal periodic tick. The tick comes from a prescaler of `PRE_DIV` clocks followed by `PRE_COUNT` prescaled counts. The defaults give 512 µs at 125 MHz. The debounce length and the switchover delay are inputs counted in ticks.

The sequencer has three named states. `SEQ_STEADY` holds the current enable. `SEQ_OVERLAP` holds the old and new enables together. `SEQ_GAP` holds every enable off. Transitions, all taken only on a tick:
- TAKE: STEADY→STEADY, from all-off to a requested channel.
- DROP: STEADY→STEADY, from a channel to all-off when nothing is requested.
- START: STEADY→OVERLAP or STEADY→GAP, when the requested channel differs from the active one.
- COUNT: OVERLAP/GAP→same state, while the delay counter is above one.
- FINISH: OVERLAP/GAP→STEADY, when the delay expires.

Top module: `relay_switchover_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted request, `ch_en` is 3'b000.
- R2: A tick occurs on every `PRE_DIV*PRE_COUNT`-th clock edge after reset release, the first being edge number `PRE_DIV*PRE_COUNT`. `ch_en` changes only on tick edges.
- R3: Each `sw_req_n` bit goes through a two-flop synchronizer. Its accepted level changes only after the synchronized level has differed from it on `max(debounce_ticks,1)` consecutive ticks. A shorter pulse is ignored.
- R4: A switch bit at 0 requests the channel of the same index, and `ch_en[i]` at 1 enables channel i. When several are requested, the lowest index wins.
- R5: With `mode_sel`=0 (overlap), a change of channel first sets the new enable, keeping the old one. After `max(switch_delay,1)` ticks the new enable is left alone.
- R6: With `mode_sel`=1 (deadband), a change of channel first clears all enables. After `max(switch_delay,1)` ticks only the new enable is set.
- R7: From all-off, a request turns its enable on at the next tick with no delay.
- R8: With no request and no sequence running, all enables clear at the next tick with no delay.
- R9: Mode and delay are captured when a sequence starts. Request changes during a sequence are held, then evaluated afresh on the first tick after it finishes.
- R10: Outside an overlap, at most one enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_n | input | NCH | Switch lines, 0 = channel requested |
| mode_sel | input | 1 | 0 = overlap, 1 = deadband |
| switch_delay | input | DLY_W | Delay between the two edges, in ticks |
| debounce_ticks | input | DB_W | Stable ticks needed to accept a switch level |
| ch_en | output | NCH | Active-high channel enables |

## Verification
A wrong sequencer state shows at `ch_en` on the very next tick. A stuck overlap shows two enables high past the delay, a stuck gap leaves the relays dark, and a lost target enables the wrong bit. A debounce counter that is off by one moves the first enable edge by a whole tick. The bench therefore compares `ch_en` against a tick-level model on every clock, which pins each error to within one tick period of its cause.

// File: rtl/rss_pkg.sv
package rss_pkg;

    typedef enum logic [1:0] {
        SEQ_STEADY  = 2'd0,
        SEQ_OVERLAP = 2'd1,
        SEQ_GAP     = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_TAKE   = 3'd1,
        EV_DROP   = 3'd2,
        EV_START  = 3'd3,
        EV_COUNT  = 3'd4,
        EV_FINISH = 3'd5
    } seq_event_e;

    localparam logic MODE_OVERLAP  = 1'b0;
    localparam logic MODE_DEADBAND = 1'b1;

endpackage

// File: rtl/rss_tick_gen.sv
module rss_tick_gen #(
    parameter int PRE_DIV   = 250,
    parameter int PRE_COUNT = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRE_DIV   > 1) ? $clog2(PRE_DIV)   : 1;
    localparam int SW = (PRE_COUNT > 1) ? $clog2(PRE_COUNT) : 1;

    logic [PW-1:0] pre_cnt;
    logic [SW-1:0] sub_cnt;
    logic          pre_wrap;
    logic          sub_wrap;

    assign pre_wrap = (pre_cnt == PW'(PRE_DIV - 1));
    assign sub_wrap = (sub_cnt == SW'(PRE_COUNT - 1));
    assign tick     = pre_wrap && sub_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                if (sub_wrap) sub_cnt <= '0;
                else          sub_cnt <= sub_cnt + SW'(1);
            end else begin
                pre_cnt <= pre_cnt + PW'(1);
            end
        end
    end

    generate
        if (PRE_DIV * PRE_COUNT > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/rss_debounce.sv
module rss_debounce #(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            raw_n,
    input  logic [DB_W-1:0] limit_in,
    output logic            level_n
);
    logic            sync1;
    logic            sync2;
    logic [DB_W-1:0] run_cnt;
    logic [DB_W:0]   limit_eff;
    logic [DB_W:0]   run_next;

    assign limit_eff = (limit_in == '0) ? (DB_W+1)'(1) : {1'b0, limit_in};
    assign run_next  = {1'b0, run_cnt} + (DB_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw_n;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_n <= 1'b1;
            run_cnt <= '0;
        end else if (tick) begin
            if (sync2 != level_n) begin
                if (run_next >= limit_eff) begin
                    level_n <= sync2;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_next[DB_W-1:0];
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level_n)); // R3

endmodule

// File: rtl/rss_select.sv
module rss_select #(
    parameter int NCH = 3,
    parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] level_n,
    output logic           req_valid,
    output logic [IW-1:0]  req_idx
);
    always_comb begin
        req_valid = 1'b0;
        req_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!level_n[i]) begin
                req_valid = 1'b1;
                req_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/relay_switchover_seq.sv
module relay_switchover_seq
    import rss_pkg::*;
#(
    parameter int NCH       = 3,
    parameter int DLY_W     = 8,
    parameter int DB_W      = 8,
    parameter int PRE_DIV   = 250,
    parameter int PRE_COUNT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   sw_req_n,
    input  logic             mode_sel,
    input  logic [DLY_W-1:0] switch_delay,
    input  logic [DB_W-1:0]  debounce_ticks,
    output logic [NCH-1:0]   ch_en
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [NCH-1:0] ONE = NCH'(1);

    logic            tick;
    logic [NCH-1:0]  level_n;
    logic            req_valid;
    logic [IW-1:0]   req_idx;

    seq_state_e      state_q, state_d;
    seq_event_e      ev;
    logic            cur_valid;
    logic [IW-1:0]   cur_idx;
    logic [IW-1:0]   tgt_idx;
    logic [DLY_W-1:0] timer_q;

    rss_tick_gen #(
        .PRE_DIV   (PRE_DIV),
        .PRE_COUNT (PRE_COUNT)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_db
            rss_debounce #(.DB_W(DB_W)) u_db (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .raw_n    (sw_req_n[g]),
                .limit_in (debounce_ticks),
                .level_n  (level_n[g])
            );
        end
    endgenerate

    rss_select #(.NCH(NCH), .IW(IW)) u_sel (
        .level_n   (level_n),
        .req_valid (req_valid),
        .req_idx   (req_idx)
    );

    // Next state and event decode
    always_comb begin
        state_d = state_q;
        ev      = EV_NONE;
        if (tick) begin
            unique case (state_q)
                SEQ_STEADY: begin
                    if (!req_valid && cur_valid) begin
                        ev = EV_DROP;
                    end else if (req_valid && !cur_valid) begin
                        ev = EV_TAKE;
                    end else if (req_valid && (req_idx != cur_idx)) begin
                        ev      = EV_START;
                        state_d = (mode_sel == MODE_OVERLAP) ? SEQ_OVERLAP : SEQ_GAP;
                    end
                end
                SEQ_OVERLAP, SEQ_GAP: begin
                    if (timer_q <= DLY_W'(1)) begin
                        ev      = EV_FINISH;
                        state_d = SEQ_STEADY;
                    end else begin
                        ev = EV_COUNT;
                    end
                end
                default: state_d = SEQ_STEADY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_STEADY;
        else        state_q <= state_d;
    end

    // Outputs and sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en     <= '0;
            cur_valid <= 1'b0;
            cur_idx   <= '0;
            tgt_idx   <= '0;
            timer_q   <= '0;
        end else begin
            unique case (ev)
                EV_TAKE: begin
                    ch_en     <= ONE << req_idx;
                    cur_valid <= 1'b1;
                    cur_idx   <= req_idx;
                end
                EV_DROP: begin
                    ch_en     <= '0;
                    cur_valid <= 1'b0;
                end
                EV_START: begin
                    tgt_idx <= req_idx;
                    timer_q <= switch_delay;
                    if (mode_sel == MODE_OVERLAP) ch_en <= ch_en | (ONE << req_idx);
                    else                          ch_en <= '0;
                end
                EV_COUNT: begin
                    timer_q <= timer_q - DLY_W'(1);
                end
                EV_FINISH: begin
                    ch_en   <= ONE << tgt_idx;
                    cur_idx <= tgt_idx;
                end
                default: ;
            endcase
        end
    end

    AST_STEADY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_STEADY) |-> $onehot0(ch_en)); // R10
    AST_OVERLAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_OVERLAP) |-> ($countones(ch_en) == 2)); // R5
    AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GAP) |-> (ch_en == '0)); // R6
    AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ch_en)); // R2
    AST_HELD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_STEADY) && !(tick && timer_q <= DLY_W'(1)) |=> $stable(tgt_idx)); // R9

endmodule

// File: tb/sim_relay_switchover_seq.sv
`timescale 1ns/1ps
module sim_relay_switchover_seq;
    localparam int NCH  = 3;
    localparam int DLYW = 8;
    localparam int DBW  = 8;
    localparam int PD   = 2;
    localparam int PC   = 4;
    localparam int TICK = PD * PC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  sw_n = '1;
    logic            mode = 1'b0;
    logic [DLYW-1:0] dly = '0;
    logic [DBW-1:0]  dbc = '0;
    logic [NCH-1:0]  ch_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    relay_switchover_seq #(
        .NCH(NCH), .DLY_W(DLYW), .DB_W(DBW), .PRE_DIV(PD), .PRE_COUNT(PC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sw_req_n(sw_n), .mode_sel(mode),
        .switch_delay(dly), .debounce_ticks(dbc), .ch_en(ch_en)
    );

    // tick-level reference model
    int             n;
    logic [NCH-1:0] m_s1, m_s2, m_acc, m_out;
    int             m_cnt [NCH];
    int             m_st;       // 0 steady, 1 overlap, 2 gap
    bit             m_cv;
    int             m_cur, m_tgt, m_tmr;
    int             seen_pair, seen_dark;

    task automatic model_reset();
        n = 0; m_s1 = '1; m_s2 = '1; m_acc = '1; m_out = '0;
        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        m_st = 0; m_cv = 0; m_cur = 0; m_tgt = 0; m_tmr = 0;
    endtask

    task automatic model_step();
        bit rv; int ridx; int lim;
        n++;
        if (n % TICK == 0) begin
            rv = 0; ridx = 0;
            for (int i = NCH - 1; i >= 0; i--) if (!m_acc[i]) begin rv = 1; ridx = i; end
            if (m_st == 0) begin
                if (!rv && m_cv) begin m_out = '0; m_cv = 0; end
                else if (rv && !m_cv) begin m_out = NCH'(1 << ridx); m_cv = 1; m_cur = ridx; end
                else if (rv && ridx != m_cur) begin
                    m_tgt = ridx; m_tmr = int'(dly);
                    if (!mode) begin m_out = m_out | NCH'(1 << ridx); m_st = 1; end
                    else       begin m_out = '0; m_st = 2; end
                end
            end else begin
                if (m_tmr <= 1) begin m_out = NCH'(1 << m_tgt); m_cur = m_tgt; m_st = 0; end
                else m_tmr--;
            end
            lim = (dbc == 0) ? 1 : int'(dbc);
            for (int i = 0; i < NCH; i++) begin
                if (m_s2[i] != m_acc[i]) begin
                    m_cnt[i]++;
                    if (m_cnt[i] >= lim) begin m_acc[i] = m_s2[i]; m_cnt[i] = 0; end
                end else m_cnt[i] = 0;
            end
        end
        m_s2 = m_s1; m_s1 = sw_n;
    endtask

    task automatic check(input bit ok, input string req, input logic [NCH-1:0] act,
                         input logic [NCH-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: ch_en actual %b expected %b at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input int cyc, input string label);
        for (int k = 0; k < cyc; k++) begin
            model_step();
            @(negedge clk);
            if (m_st == 1)      check(ch_en == m_out, "R5 overlap", ch_en, m_out);
            else if (m_st == 2) check(ch_en == m_out, "R6 deadband", ch_en, m_out);
            else                check(ch_en == m_out, label, ch_en, m_out);
            if (m_st == 1 && $countones(ch_en) == 2) seen_pair++;
            if (m_st == 2 && ch_en == '0) seen_dark++;
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        seen_pair = 0; seen_dark = 0;
        sw_n = '1; dbc = 8'd1; dly = 8'd3; mode = 1'b0;
        repeat (3) @(negedge clk);
        check(ch_en == '0, "R1 reset", ch_en, '0);
        sw_n = 3'b110;                       // request during reset: ignored
        @(negedge clk);
        check(ch_en == '0, "R1 reset held", ch_en, '0);
        rst_n = 1'b1;
        run(40, "R2 R7 first take");
        sw_n = 3'b101; run(80, "R5 to channel 1");
        mode = 1'b1; sw_n = 3'b011; run(80, "R6 to channel 2");
        sw_n = 3'b000; run(60, "R4 priority");
        dbc = 8'd4;
        sw_n = 3'b111; run(16, "R3 short release");
        sw_n = 3'b000; run(80, "R3 glitch ignored");
        sw_n = 3'b111; run(80, "R8 release");
        mode = 1'b0; dly = 8'd6; dbc = 8'd1;
        sw_n = 3'b110; run(40, "R7 take");
        sw_n = 3'b101; run(24, "R9 start");
        mode = 1'b1; sw_n = 3'b011; run(100, "R9 held request");
        for (int r = 0; r < 300; r++) begin
            sw_n = NCH'($urandom_range(0, 7));
            mode = 1'($urandom_range(0, 1));
            dly  = DLYW'($urandom_range(0, 5));
            dbc  = DBW'($urandom_range(0, 3));
            run($urandom_range(4, 60), "R4 R10 random");
        end
        check(seen_pair > 0, "R5 pair seen", NCH'(seen_pair > 0), NCH'(1));
        check(seen_dark > 0, "R6 gap seen", NCH'(seen_dark > 0), NCH'(1));
        done = 1;
        report();
    end
endmodule